// File: doc/BRIEF.md
# Multi-Channel Block-Move DMA Sequencer

This block moves bytes between a wide memory-side bus (24-bit address, called the A side here) and a narrow peripheral bus whose register page is fixed at 0x21 (the B side). A single start pulse launches one pass over all channels. The pass opens with a fixed setup overhead. The channels whose enable bit was set when the pass began are then serviced strictly in ascending index order, and each one costs its own lead-in overhead before its first byte. Each byte takes eight clocks: a read strobe in the fourth clock and a write strobe in the eighth. One clock of the block stands for one master clock.

The sequencer recognises a work-RAM-to-work-RAM path, which would make both buses drive the same storage. It then suppresses the conflicting access in a way that depends on the direction. In the peripheral-to-memory direction it also drops writes to addresses that are not valid targets. When the last channel finishes, a lock flag is raised for two clocks. A free-running accounting output gives the number of clocks the pass has spent. The channel configuration is read live from the inputs and must be held steady while the block is busy. Address stepping and transfer patterns are not part of this block: each channel uses one fixed address pair.

Top module: `dma_seq`

## Requirements
- R1: A start pulse accepted while idle raises `busy` in the next clock and clears `cyc_cnt`. The pass spends exactly 8 busy clocks of setup before any channel work begins.
- R2: Channels whose `ch_en` bit was set at start are serviced in ascending index order, and each one costs 8 lead-in clocks before its first byte. A channel that was not enabled costs no clock. A pass with no channel enabled goes directly from setup to the lock phase.
- R3: Every byte takes 8 clocks, and the read strobe and the write strobe are each one clock wide. In the A-to-B direction (`ch_dir` bit = 0), `a_rd` is high in the 4th clock of the byte. `b_wr` is high in the 8th clock and carries the byte that was read.
- R4: `b_addr` is {8'h21, the channel's 8-bit B offset}. `a_addr` is the channel's 24-bit address.
- R5: A transfer is a conflict when the B offset is 8'h80 and either the address lies in banks 0x7E–0x7F or (address AND 24'h40E000) is zero. An A-to-B conflict still takes 8 clocks but raises no strobe on either bus.
- R6: A B-to-A conflict (`ch_dir` bit = 1) takes 8 clocks and raises no `b_rd`. It raises `a_wr` in the 8th clock with `a_wdata` = 8'h00.
- R7: A legal B-to-A byte raises `b_rd` in the 4th clock. It raises `a_wr` with the byte read in the 8th clock, but only when the address is valid. An address is invalid when bit 22 is 0 and bits 15:0 lie in 0x2100–0x21FF or 0x4300–0x437F. A dropped write still takes the full 8 clocks.
- R8: The count is decremented after each byte, and the channel goes on while the result is non-zero and its live `ch_en` bit is still high at the byte's last clock. A starting count of 0 gives 2^CW bytes. The channel's `ch_active` bit clears at the end of its last byte.
- R9: After the last channel, or after setup when no channel is enabled, `irq_lock` is high for exactly 2 clocks while `busy` is low. The block is then idle.
- R10: A start pulse during a busy clock or a lock clock is ignored.
- R11: `cyc_cnt` increases by one on every busy clock and holds its value when not busy. At the end of a pass it equals 8 + Σ(8 + 8·bytes) over the serviced channels.
- R12: After reset, `busy`, `irq_lock`, every strobe, `ch_active` and `cyc_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one master clock per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for one pass |
| ch_en | input | NCH | Per-channel enable (latched at start, sampled live to abort) |
| ch_dir | input | NCH | Per-channel direction, 0 = A to B, 1 = B to A |
| ch_boff | input | NCH*8 | Per-channel B-bus offset, channel i at bits 8i+7:8i |
| ch_addr | input | NCH*AW | Per-channel A-bus address |
| ch_count | input | NCH*CW | Per-channel byte count, 0 means 2^CW |
| a_addr | output | AW | A-bus address |
| a_rd | output | 1 | A-bus read strobe |
| a_wr | output | 1 | A-bus write strobe |
| a_wdata | output | 8 | A-bus write data |
| a_rdata | input | 8 | A-bus read data, valid in the strobe clock |
| b_addr | output | 16 | B-bus address |
| b_rd | output | 1 | B-bus read strobe |
| b_wr | output | 1 | B-bus write strobe |
| b_wdata | output | 8 | B-bus write data |
| b_rdata | input | 8 | B-bus read data, valid in the strobe clock |
| busy | output | 1 | High from setup until the lock phase |
| irq_lock | output | 1 | Two-clock lock flag at the end of a pass |
| ch_active | output | NCH | Channels still owed service in this pass |
| cyc_cnt | output | 32 | Clocks spent in the current or last pass |

## Verification
The hardest situation to reach is a channel cut short by its live enable. The bench must drop the enable in exactly the last clock of a chosen byte, so its reference model records the queue index of that clock while it builds the expected trace, and the drive loop clears the bit at that index. The count-of-zero wrap would need 65536 bytes at the default width. The bench therefore builds the block with an 8-bit count, so the 256-byte wrap finishes within the run. Both conflict directions and both invalid-address windows are set up by choosing B offsets and addresses directly. A second start pulse is placed in a busy clock and in a lock clock.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CHAN,
        ST_XFER,
        ST_LOCK
    } seq_st_e;

    localparam logic [2:0] PH_LAST  = 3'd7;
    localparam logic [2:0] PH_READ  = 3'd3;
    localparam logic [2:0] PH_LOCK  = 3'd1;
    localparam logic [7:0] B_PAGE   = 8'h21;
    localparam logic [7:0] WRAM_OFF = 8'h80;

endpackage

// File: rtl/dma_seq_class.sv
module dma_seq_class #(
    parameter int AW = 24
) (
    input  logic [7:0]    boff,
    input  logic [AW-1:0] addr,
    output logic          conflict,
    output logic          addr_ok
);
    import dma_seq_pkg::*;

    localparam logic [AW-1:0] BANK_MASK = AW'(24'hFE0000);
    localparam logic [AW-1:0] BANK_WRAM = AW'(24'h7E0000);
    localparam logic [AW-1:0] LOW_MASK  = AW'(24'h40E000);

    logic in_wram_bank;
    logic in_low_mirror;
    logic sys_half;

    always_comb begin
        in_wram_bank  = (addr & BANK_MASK) == BANK_WRAM;
        in_low_mirror = (addr & LOW_MASK) == '0;
        conflict      = (boff == WRAM_OFF) && (in_wram_bank || in_low_mirror);
        sys_half      = !addr[22];
        addr_ok       = !(sys_half && ((addr[15:8] == 8'h21) ||
                                       (addr[15:7] == 9'h086)));
    end

endmodule

// File: rtl/dma_seq_pick.sv
module dma_seq_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
    parameter int NCH = 8,
    parameter int AW  = 24,
    parameter int CW  = 16,
    localparam int CHW   = $clog2(NCH),
    localparam int CYC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_dir,
    input  logic [NCH*8-1:0]  ch_boff,
    input  logic [NCH*AW-1:0] ch_addr,
    input  logic [NCH*CW-1:0] ch_count,
    output logic [AW-1:0]     a_addr,
    output logic              a_rd,
    output logic              a_wr,
    output logic [7:0]        a_wdata,
    input  logic [7:0]        a_rdata,
    output logic [15:0]       b_addr,
    output logic              b_rd,
    output logic              b_wr,
    output logic [7:0]        b_wdata,
    input  logic [7:0]        b_rdata,
    output logic              busy,
    output logic              irq_lock,
    output logic [NCH-1:0]    ch_active,
    output logic [CYC_W-1:0]  cyc_cnt
);
    import dma_seq_pkg::*;

    typedef struct packed {
        seq_st_e          st;
        logic [2:0]       ph;
        logic [CHW-1:0]   ch;
        logic [CW-1:0]    cnt;
        logic [NCH-1:0]   act;
        logic [7:0]       data;
        logic [CYC_W-1:0] cyc;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic           cur_dir;
    logic [7:0]     cur_boff;
    logic [AW-1:0]  cur_addr;
    logic [CW-1:0]  cur_cnt_in;
    logic           conflict;
    logic           addr_ok;
    logic [NCH-1:0] pick_req;
    logic           pick_any;
    logic [CHW-1:0] pick_idx;
    logic [CW-1:0]  cnt_m1;
    logic           in_xfer;
    logic           rd_ph;
    logic           wr_ph;

    assign cur_dir    = ch_dir[r_q.ch];
    assign cur_boff   = ch_boff[r_q.ch*8 +: 8];
    assign cur_addr   = ch_addr[r_q.ch*AW +: AW];
    assign cur_cnt_in = ch_count[r_q.ch*CW +: CW];
    assign cnt_m1     = r_q.cnt - 1'b1;

    dma_seq_class #(.AW(AW)) u_class (
        .boff     (cur_boff),
        .addr     (cur_addr),
        .conflict (conflict),
        .addr_ok  (addr_ok)
    );

    // the channel being finished is masked so the picker yields the next one up
    always_comb begin
        pick_req = r_q.act;
        if (r_q.st == ST_XFER) pick_req[r_q.ch] = 1'b0;
    end

    dma_seq_pick #(.N(NCH)) u_pick (
        .req (pick_req),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st  = ST_SETUP;
                    r_d.ph  = '0;
                    r_d.act = ch_en;
                    r_d.cyc = '0;
                end
            end
            ST_SETUP: begin
                r_d.cyc = r_q.cyc + 1'b1;
                r_d.ph  = r_q.ph + 1'b1;
                if (r_q.ph == PH_LAST) begin
                    r_d.ph = '0;
                    if (pick_any) begin
                        r_d.st = ST_CHAN;
                        r_d.ch = pick_idx;
                    end else begin
                        r_d.st = ST_LOCK;
                    end
                end
            end
            ST_CHAN: begin
                r_d.cyc = r_q.cyc + 1'b1;
                r_d.ph  = r_q.ph + 1'b1;
                if (r_q.ph == PH_LAST) begin
                    r_d.st  = ST_XFER;
                    r_d.ph  = '0;
                    r_d.cnt = cur_cnt_in;
                end
            end
            ST_XFER: begin
                r_d.cyc = r_q.cyc + 1'b1;
                r_d.ph  = r_q.ph + 1'b1;
                if (r_q.ph == PH_READ && !conflict)
                    r_d.data = cur_dir ? b_rdata : a_rdata;
                if (r_q.ph == PH_LAST) begin
                    r_d.ph = '0;
                    if (cnt_m1 != '0 && ch_en[r_q.ch]) begin
                        r_d.cnt = cnt_m1;
                    end else begin
                        r_d.act[r_q.ch] = 1'b0;
                        if (pick_any) begin
                            r_d.st = ST_CHAN;
                            r_d.ch = pick_idx;
                        end else begin
                            r_d.st = ST_LOCK;
                        end
                    end
                end
            end
            ST_LOCK: begin
                r_d.ph = r_q.ph + 1'b1;
                if (r_q.ph == PH_LOCK) begin
                    r_d.st = ST_IDLE;
                    r_d.ph = '0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_xfer = r_q.st == ST_XFER;
    assign rd_ph   = in_xfer && r_q.ph == PH_READ;
    assign wr_ph   = in_xfer && r_q.ph == PH_LAST;

    assign busy      = r_q.st inside {ST_SETUP, ST_CHAN, ST_XFER};
    assign irq_lock  = r_q.st == ST_LOCK;
    assign ch_active = r_q.act;
    assign cyc_cnt   = r_q.cyc;
    assign a_addr    = cur_addr;
    assign b_addr    = {B_PAGE, cur_boff};
    assign a_rd      = rd_ph && !cur_dir && !conflict;
    assign b_rd      = rd_ph &&  cur_dir && !conflict;
    assign b_wr      = wr_ph && !cur_dir && !conflict;
    assign a_wr      = wr_ph &&  cur_dir && (conflict || addr_ok);
    assign a_wdata   = conflict ? 8'h00 : r_q.data;
    assign b_wdata   = r_q.data;

    // B-side write always follows its A-side read by four clocks
    p_bwr_after_ard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        b_wr |-> $past(a_rd, 4));

    // an A-side write not fed by a B-side read must be the conflict zero
    p_zero_on_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && !$past(b_rd, 4)) |-> a_wdata == 8'h00);

    p_lock_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_lock) |=> irq_lock ##1 !irq_lock);

    p_lock_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lock |-> !busy);

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> cyc_cnt != '0);

    p_cyc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cyc_cnt == $past(cyc_cnt) + 1);

    p_act_only_falls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (ch_active & ~$past(ch_active)) == '0);

endmodule

// File: tb/sim_dma_seq.sv
module sim_dma_seq;
    localparam int NCH = 8;
    localparam int AW  = 24;
    localparam int CW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NCH-1:0]    ch_en = '0;
    logic [NCH-1:0]    ch_dir = '0;
    logic [NCH*8-1:0]  ch_boff;
    logic [NCH*AW-1:0] ch_addr;
    logic [NCH*CW-1:0] ch_count;
    logic [AW-1:0]     a_addr;
    logic              a_rd, a_wr, b_rd, b_wr;
    logic [7:0]        a_wdata, a_rdata, b_wdata, b_rdata;
    logic [15:0]       b_addr;
    logic              busy, irq_lock;
    logic [NCH-1:0]    ch_active;
    logic [31:0]       cyc_cnt;

    logic [7:0]    cfg_boff [NCH];
    logic [AW-1:0] cfg_addr [NCH];
    logic [CW-1:0] cfg_cnt  [NCH];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ch_boff[i*8 +: 8]    = cfg_boff[i];
            ch_addr[i*AW +: AW]  = cfg_addr[i];
            ch_count[i*CW +: CW] = cfg_cnt[i];
        end
    end

    // memory stubs
    assign a_rdata = a_addr[7:0] ^ a_addr[15:8] ^ 8'hA5;
    assign b_rdata = b_addr[7:0] + 8'h3C;

    dma_seq #(.NCH(NCH), .AW(AW), .CW(CW)) u0 (
        .clk, .rst_n, .start, .ch_en, .ch_dir, .ch_boff, .ch_addr, .ch_count,
        .a_addr, .a_rd, .a_wr, .a_wdata, .a_rdata,
        .b_addr, .b_rd, .b_wr, .b_wdata, .b_rdata,
        .busy, .irq_lock, .ch_active, .cyc_cnt
    );

    typedef struct {
        bit          busy, irq, ard, awr, brd, bwr;
        logic [23:0] aa;
        logic [15:0] ba;
        logic [7:0]  wd;
        logic [7:0]  act;
        int          cnt;
    } exp_t;

    exp_t q[$];
    int   abort_idx;

    task automatic chk(input bit ok, input string what, input string req,
                       input longint actv, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, actv, expv, $time);
        end
    endtask

    function automatic bit is_conflict(input logic [7:0] bo, input logic [23:0] ad);
        return bo == 8'h80 && (ad[23:17] == 7'h3F || (ad & 24'h40E000) == 24'h0);
    endfunction

    function automatic bit is_valid(input logic [23:0] ad);
        if (ad[22]) return 1'b1;
        if (ad[15:0] >= 16'h2100 && ad[15:0] <= 16'h21FF) return 1'b0;
        if (ad[15:0] >= 16'h4300 && ad[15:0] <= 16'h437F) return 1'b0;
        return 1'b1;
    endfunction

    function automatic exp_t mk(input bit bz, input bit ir, input logic [7:0] ac, input int t);
        exp_t e;
        e = '{busy: bz, irq: ir, ard: 0, awr: 0, brd: 0, bwr: 0,
              aa: '0, ba: '0, wd: '0, act: ac, cnt: t};
        return e;
    endfunction

    // behavioural reference: expected outputs for every clock of one pass
    task automatic build(input int ab_ch, input int ab_byte);
        logic [7:0] act;
        int t;
        exp_t e;
        q.delete();
        abort_idx = -1;
        act = ch_en;
        t = 0;
        for (int k = 0; k < 8; k++) begin q.push_back(mk(1, 0, act, t)); t++; end
        for (int c = 0; c < NCH; c++) begin
            int n;
            bit ill;
            logic [7:0] d;
            if (!ch_en[c]) continue;
            for (int k = 0; k < 8; k++) begin q.push_back(mk(1, 0, act, t)); t++; end
            n = (cfg_cnt[c] == 0) ? (1 << CW) : int'(cfg_cnt[c]);
            if (c == ab_ch && ab_byte + 1 < n) n = ab_byte + 1;
            ill = is_conflict(cfg_boff[c], cfg_addr[c]);
            d = ch_dir[c] ? cfg_boff[c] + 8'h3C
                          : cfg_addr[c][7:0] ^ cfg_addr[c][15:8] ^ 8'hA5;
            for (int b = 0; b < n; b++) begin
                for (int p = 0; p < 8; p++) begin
                    e = mk(1, 0, act, t);
                    if (p == 3 && !ill) begin
                        if (ch_dir[c]) begin e.brd = 1; e.ba = {8'h21, cfg_boff[c]}; end
                        else begin e.ard = 1; e.aa = cfg_addr[c]; end
                    end
                    if (p == 7) begin
                        if (!ch_dir[c] && !ill) begin
                            e.bwr = 1; e.ba = {8'h21, cfg_boff[c]}; e.wd = d;
                        end
                        if (ch_dir[c] && ill) begin
                            e.awr = 1; e.aa = cfg_addr[c]; e.wd = 8'h00;
                        end
                        if (ch_dir[c] && !ill && is_valid(cfg_addr[c])) begin
                            e.awr = 1; e.aa = cfg_addr[c]; e.wd = d;
                        end
                        if (c == ab_ch && b == ab_byte) abort_idx = q.size();
                    end
                    q.push_back(e);
                    t++;
                end
            end
            act[c] = 1'b0;
        end
        q.push_back(mk(0, 1, act, t));
        q.push_back(mk(0, 1, act, t));
        q.push_back(mk(0, 0, act, t));
        q.push_back(mk(0, 0, act, t));
    endtask

    task automatic compare(input exp_t e, input string req);
        chk(busy == e.busy, "busy", req, busy, e.busy);
        chk(irq_lock == e.irq, "irq_lock", req, irq_lock, e.irq);
        chk(a_rd == e.ard, "a_rd", req, a_rd, e.ard);
        chk(a_wr == e.awr, "a_wr", req, a_wr, e.awr);
        chk(b_rd == e.brd, "b_rd", req, b_rd, e.brd);
        chk(b_wr == e.bwr, "b_wr", req, b_wr, e.bwr);
        chk(ch_active == e.act, "ch_active", req, ch_active, e.act);
        chk(cyc_cnt == 32'(e.cnt), "cyc_cnt", req, cyc_cnt, e.cnt);
        if (e.ard || e.awr) chk(a_addr == e.aa, "a_addr", req, a_addr, e.aa);
        if (e.brd || e.bwr) chk(b_addr == e.ba, "b_addr", req, b_addr, e.ba);
        if (e.awr) chk(a_wdata == e.wd, "a_wdata", req, a_wdata, e.wd);
        if (e.bwr) chk(b_wdata == e.wd, "b_wdata", req, b_wdata, e.wd);
    endtask

    // glitch_busy: index of a busy clock that gets a stray start (R10)
    task automatic run(input string req, input int ab_ch, input int ab_byte, input int glitch_busy);
        int lock0;
        build(ab_ch, ab_byte);
        lock0 = q.size() - 4;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int j = 0; j < q.size(); j++) begin
            compare(q[j], req);
            start = (j == glitch_busy || j == lock0) ? 1'b1 : 1'b0;
            if (j == abort_idx) ch_en[ab_ch] = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            cfg_boff[i] = 8'h00; cfg_addr[i] = 24'h000000; cfg_cnt[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!busy && !irq_lock, "busy/irq", "R12", {busy, irq_lock}, 0);
        chk(!a_rd && !a_wr && !b_rd && !b_wr, "strobes", "R12", {a_rd, a_wr, b_rd, b_wr}, 0);
        chk(ch_active == 0 && cyc_cnt == 0, "act/cnt", "R12", cyc_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R9 R11: plain legal moves on channels 0, 2, 5
        ch_en = 8'b0010_0101; ch_dir = 8'b0000_0100;
        cfg_boff[0] = 8'h18; cfg_addr[0] = 24'h7F1234; cfg_cnt[0] = 8'd3;
        cfg_boff[2] = 8'h40; cfg_addr[2] = 24'h7E8000; cfg_cnt[2] = 8'd2;
        cfg_boff[5] = 8'h22; cfg_addr[5] = 24'h80ABCD; cfg_cnt[5] = 8'd1;
        run("R1/R2/R3/R4/R9/R11", -1, 0, 20);

        // R5 R6: conflicts in both directions
        ch_en = 8'b0000_1010; ch_dir = 8'b0000_1000;
        cfg_boff[1] = 8'h80; cfg_addr[1] = 24'h7E1234; cfg_cnt[1] = 8'd2;
        cfg_boff[3] = 8'h80; cfg_addr[3] = 24'h001000; cfg_cnt[3] = 8'd2;
        run("R5/R6", -1, 0, 30);

        // R7: invalid targets dropped, upper-half address kept
        ch_en = 8'b0101_0010; ch_dir = 8'b0101_0010;
        cfg_boff[1] = 8'h10; cfg_addr[1] = 24'h004305; cfg_cnt[1] = 8'd1;
        cfg_boff[4] = 8'h10; cfg_addr[4] = 24'h002118; cfg_cnt[4] = 8'd2;
        cfg_boff[6] = 8'h11; cfg_addr[6] = 24'h402118; cfg_cnt[6] = 8'd1;
        run("R7", -1, 0, 12);

        // R8: live enable abort on channel 0 and zero-count wrap on channel 7
        ch_en = 8'b1000_0001; ch_dir = 8'b0000_0000;
        cfg_boff[0] = 8'h05; cfg_addr[0] = 24'h7F0010; cfg_cnt[0] = 8'd10;
        cfg_boff[7] = 8'h06; cfg_addr[7] = 24'h7F0020; cfg_cnt[7] = 8'd0;
        run("R8/R10", 0, 2, 40);

        // R2 R9: nothing enabled, setup then lock
        ch_en = 8'b0000_0000;
        run("R2/R9", -1, 0, 5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule